// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Core

This block keeps time of day and calendar date in binary-coded decimal. A clock-enable input pulses at 4096 Hz. A fractional divider turns those pulses into an exact long-term 100 Hz step. The divider is a two-state machine:

- `PH_LONG` counts periods of 41 input pulses.
- `PH_SHORT` counts one period of 40 input pulses.

The machine moves `PH_LONG -> PH_SHORT` after the 24th long period ends. It moves `PH_SHORT -> PH_LONG` when the short period ends. Any write to a time field returns it to `PH_LONG` with zero count.

Each 100 Hz step advances a BCD carry chain: hundredths, seconds, minutes, hours, then day-of-week, date, month and a two-digit year. Hours run in either a 12-hour or a 24-hour format. Date rollover follows month length and leap years.

Software-side logic writes any field through a one-cycle write port. It reads through a snapshot image: a `snap_i` pulse copies every live field into the image. Reads of that image are combinational, so a multi-byte read stays coherent while the clock keeps running. An oscillator-stop input sets a sticky status flag, which is cleared by a write.

Top module: `rtc_core`

## Requirements
- R1: With the divider phase fresh, hundredths advance on the 41st tick. Periods follow 24 of 41 ticks then one of 40, so exactly 1024 ticks give 25 hundredths, 1023 give 24 and 40 give none.
- R2: Hundredths count BCD 00-99. Seconds and minutes count BCD 00-59. Each wraps to 00 and carries into the next field.
- R3: Hour field (address 3) bit 6 = 0 selects 24-hour mode, with bits 5:0 holding BCD 00-23. 23 wraps to 00 and carries into the date.
- R4: Hour bit 6 = 1 selects 12-hour mode. Bit 5 = 1 means PM and bits 4:0 hold BCD 01-12. 11 AM goes to 12 PM with no date carry. 11 PM goes to 12 AM with a date carry. 12 goes to 01 with the PM bit unchanged.
- R5: Date rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. February rolls after 29 when the year is divisible by 4 and after 28 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R6: Day-of-week (address 4) advances once per date carry and wraps from 07 to 01.
- R7: After reset every time field and the status register read 00.
- R8: A `snap_i` high at a clock edge copies all live registers into the read image. `rd_data_o` shows the image byte at `rd_addr_i` combinationally, and the image does not follow the live clock until the next snapshot.
- R9: A write with `wr_en_i` high to address 0-7 replaces that field at the next edge. The addresses are: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day-of-week, 5 date, 6 month, 7 year.
- R10: A write to address 0-7 resets the divider phase, so the next hundredth follows 41 ticks after the write.
- R11: Status (address 8) bit 7 is set while `osc_stop_i` is high and stays set. A write to address 8 with bit 7 = 0 clears it, and a write with bit 7 = 1 has no effect. Bits 6:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 4096 Hz clock-enable pulse |
| osc_stop_i | input | 1 | Oscillator-stop indication, sets sticky flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 8 | Write data |
| snap_i | input | 1 | Copy live registers into read image |
| rd_addr_i | input | 4 | Read address into image |
| rd_data_o | output | 8 | Image byte at `rd_addr_i` |

## Verification
A field write lands one edge after the strobe. A snapshot lands one edge after `snap_i`, and the image byte is then visible combinationally. The bench therefore drives inputs on falling edges, pulses `snap_i` for one cycle, and samples a nanosecond after changing the read address.

A hundredth step is due at the edge of the 41st enabled tick counted from a fresh phase. Each vector therefore holds `tick_i` for an exact number of cycles (40, 41, 1023 or 1024) before taking its snapshot. The phase-reset check places a write 30 ticks into a period and then confirms nothing moves 40 ticks later but does move on the 41st.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Live register set; field order matches write/read addresses 7..0.
    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
        logic [7:0] hs;
    } rtc_time_t;

    localparam int unsigned NUM_FIELDS  = 8;
    localparam logic [3:0]  STATUS_ADDR = 4'd8;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'd1, 4'h0};
        return v + 8'd1;
    endfunction

    // Year divisible by 4: 10*tens contributes 2*(tens & 1) modulo 4.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [3:0] s;
        s = yr[3:0] + {2'b00, yr[4], 1'b0};
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_frac_div.sv
module rtc_frac_div #(
    parameter int unsigned LONG_DIV  = 41,
    parameter int unsigned LONG_REPS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic step_o
);
    localparam int unsigned CW = $clog2(LONG_DIV);
    localparam int unsigned RW = $clog2(LONG_REPS + 1);

    typedef enum logic {PH_LONG, PH_SHORT} phase_t;

    phase_t        state;
    logic [CW-1:0] cnt;
    logic [RW-1:0] reps;
    logic [CW-1:0] lim;
    logic          at_end;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_LONG;
            cnt   <= '0;
            reps  <= '0;
        end else if (clr_i) begin
            state <= PH_LONG;
            cnt   <= '0;
            reps  <= '0;
        end else if (tick_i) begin
            if (at_end) begin
                cnt <= '0;
                unique case (state)
                    PH_LONG: begin
                        if (reps == RW'(LONG_REPS - 1)) begin
                            reps  <= '0;
                            state <= PH_SHORT;
                        end else begin
                            reps <= reps + 1'b1;
                        end
                    end
                    PH_SHORT: state <= PH_LONG;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            PH_LONG:  lim = CW'(LONG_DIV - 1);
            PH_SHORT: lim = CW'(LONG_DIV - 2);
        endcase
        at_end = (cnt == lim);
        step_o = tick_i && !clr_i && at_end;
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic       wr_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output rtc_time_t  time_o
);
    rtc_time_t  t, nxt;
    logic [7:0] hr_inc;
    logic       day_carry;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t <= '0;
        end else if (wr_i) begin
            t[wr_sel_i*8 +: 8] <= wr_data_i;
        end else if (step_i) begin
            t <= nxt;
        end
    end

    always_comb begin
        nxt       = t;
        day_carry = 1'b0;
        hr_inc    = bcd_inc({2'b00, t.hr[5:0]});
        nxt.hs    = (t.hs == 8'h99) ? 8'h00 : bcd_inc(t.hs);
        if (t.hs == 8'h99) begin
            nxt.sec = (t.sec == 8'h59) ? 8'h00 : bcd_inc(t.sec);
            if (t.sec == 8'h59) begin
                nxt.min = (t.min == 8'h59) ? 8'h00 : bcd_inc(t.min);
                if (t.min == 8'h59) begin
                    if (t.hr[6]) begin
                        if (t.hr[4:0] == 5'h12) begin
                            nxt.hr = {t.hr[7:5], 5'h01};
                        end else if (t.hr[4:0] == 5'h11) begin
                            nxt.hr    = {t.hr[7:6], ~t.hr[5], 5'h12};
                            day_carry = t.hr[5];
                        end else begin
                            nxt.hr = {t.hr[7:5], hr_inc[4:0]};
                        end
                    end else if (t.hr[5:0] == 6'h23) begin
                        nxt.hr    = {t.hr[7:6], 6'h00};
                        day_carry = 1'b1;
                    end else begin
                        nxt.hr = {t.hr[7:6], hr_inc[5:0]};
                    end
                end
            end
        end
        if (day_carry) begin
            nxt.dow = (t.dow == 8'h07) ? 8'h01 : bcd_inc(t.dow);
            if (t.date == last_date(t.mon, t.yr)) begin
                nxt.date = 8'h01;
                if (t.mon == 8'h12) begin
                    nxt.mon = 8'h01;
                    nxt.yr  = (t.yr == 8'h99) ? 8'h00 : bcd_inc(t.yr);
                end else begin
                    nxt.mon = bcd_inc(t.mon);
                end
            end else begin
                nxt.date = bcd_inc(t.date);
            end
        end
    end

    assign time_o = t;

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int unsigned LONG_DIV  = 41,
    parameter int unsigned LONG_REPS = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       osc_stop_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic       snap_i,
    input  logic [3:0] rd_addr_i,
    output logic [7:0] rd_data_o
);
    rtc_time_t cal, img;
    logic      hs_step;
    logic      wr_time;
    logic      st_flag, img_flag;

    assign wr_time = wr_en_i && (wr_addr_i < 4'(NUM_FIELDS));

    rtc_frac_div #(.LONG_DIV(LONG_DIV), .LONG_REPS(LONG_REPS)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .clr_i  (wr_time),
        .step_o (hs_step)
    );

    rtc_calendar u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (hs_step),
        .wr_i      (wr_time),
        .wr_sel_i  (wr_addr_i[2:0]),
        .wr_data_i (wr_data_i),
        .time_o    (cal)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_flag <= 1'b0;
        end else if (osc_stop_i) begin
            st_flag <= 1'b1;
        end else if (wr_en_i && wr_addr_i == STATUS_ADDR && !wr_data_i[7]) begin
            st_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img      <= '0;
            img_flag <= 1'b0;
        end else if (snap_i) begin
            img      <= cal;
            img_flag <= st_flag;
        end
    end

    always_comb begin
        if (rd_addr_i < 4'(NUM_FIELDS))    rd_data_o = img[rd_addr_i[2:0]*8 +: 8];
        else if (rd_addr_i == STATUS_ADDR) rd_data_o = {img_flag, 7'b0};
        else                               rd_data_o = 8'h00;
    end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       step,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       osc_stop,
    input logic       flag,
    input logic [7:0] hs,
    input logic [7:0] sec
);
    // R1: a hundredth step only happens on an input tick
    p_step_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> tick);

    // R2: hundredths hold still without a step or a write to them
    p_hs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !(wr_en && wr_addr == 4'd0)) |=> $stable(hs));

    // R2: seconds stay within BCD 00-59 when not being written
    p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 4'd1) |=> (sec[3:0] <= 4'd9 && sec[7:4] <= 4'd5));

    // R10: a time write restarts the divider period, so no step next cycle
    p_phase_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr < 4'd8) |=> !step);

    // R11: oscillator stop sets the flag
    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |=> flag);

    // R11: flag only falls on a clearing write
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && wr_addr == 4'd8 && !wr_data[7])) |=> flag);

endmodule

bind rtc_core rtc_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .step     (hs_step),
    .wr_en    (wr_en_i),
    .wr_addr  (wr_addr_i),
    .wr_data  (wr_data_i),
    .osc_stop (osc_stop_i),
    .flag     (st_flag),
    .hs       (cal.hs),
    .sec      (cal.sec)
);

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       osc_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       snap = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    rtc_core u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .osc_stop_i(osc_stop),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .snap_i(snap), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    // Fields packed {yr,mon,date,dow,hr,min,sec,hs}
    localparam int NV = 13;
    localparam logic [63:0] V_SET [NV] = '{
        64'h99_12_31_07_23_59_59_99, // R3 R5 R6 year and dow wrap
        64'h24_02_28_03_23_59_59_99, // R5 leap February
        64'h23_02_28_03_23_59_59_99, // R5 common February
        64'h24_02_29_04_23_59_59_99, // R5 leap day end
        64'h05_04_30_02_23_59_59_99, // R5 30-day month
        64'h10_06_15_05_71_59_59_99, // R4 11 PM -> 12 AM
        64'h10_06_15_05_51_59_59_99, // R4 11 AM -> 12 PM
        64'h10_06_15_05_72_59_59_99, // R4 12 PM -> 1 PM
        64'h10_06_15_05_09_59_59_99, // R2 R3 hour 09 -> 10
        64'h10_06_15_05_19_59_59_99, // R3 hour 19 -> 20
        64'h10_06_15_05_12_34_56_78, // R1 R2 1024 ticks
        64'h10_06_15_05_12_34_56_00, // R1 1023 ticks
        64'h10_06_15_05_12_34_56_00  // R1 40 ticks
    };
    localparam int V_TICKS [NV] = '{41, 41, 41, 41, 41, 41, 41, 41, 41, 41, 1024, 1023, 40};
    localparam int V_REQ   [NV] = '{5, 5, 5, 5, 5, 4, 4, 4, 3, 3, 1, 1, 1};
    localparam logic [63:0] V_EXP [NV] = '{
        64'h00_01_01_01_00_00_00_00,
        64'h24_02_29_04_00_00_00_00,
        64'h23_03_01_04_00_00_00_00,
        64'h24_03_01_05_00_00_00_00,
        64'h05_05_01_03_00_00_00_00,
        64'h10_06_16_06_52_00_00_00,
        64'h10_06_15_05_72_00_00_00,
        64'h10_06_15_05_61_00_00_00,
        64'h10_06_15_05_10_00_00_00,
        64'h10_06_15_05_20_00_00_00,
        64'h10_06_15_05_12_34_57_03,
        64'h10_06_15_05_12_34_56_24,
        64'h10_06_15_05_12_34_56_00
    };

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic take_snap();
        @(negedge clk);
        snap = 1'b1;
        @(negedge clk);
        snap = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_all(output logic [63:0] v);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            rd(4'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic set_all(input logic [63:0] v);
        for (int i = 0; i < 8; i++) wr(4'(i), v[i*8 +: 8]);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state of every field and the status register
        take_snap();
        rd_all(v);
        check("R7 fields", v, 64'h0);
        rd(4'd8, b);
        check("R7 status", {56'h0, b}, 64'h0);

        // Vector table: R1..R6 through set, tick and compare
        for (int k = 0; k < NV; k++) begin
            set_all(V_SET[k]);
            run_ticks(V_TICKS[k]);
            take_snap();
            rd_all(v);
            check($sformatf("vector %0d R%0d", k, V_REQ[k]), v, V_EXP[k]);
        end

        // R9: a single-field write lands after one edge
        wr(4'd2, 8'h42);
        take_snap();
        rd(4'd2, b);
        check("R9 minutes write", {56'h0, b}, 64'h42);

        // R10: a write mid-period restarts the 41-tick count
        set_all(64'h0);
        run_ticks(30);
        wr(4'd0, 8'h00);
        run_ticks(40);
        take_snap();
        rd(4'd0, b);
        check("R10 no step at 40", {56'h0, b}, 64'h00);
        run_ticks(1);
        take_snap();
        rd(4'd0, b);
        check("R10 step at 41", {56'h0, b}, 64'h01);

        // R8: the image stays frozen until the next snapshot
        run_ticks(41);
        rd(4'd0, b);
        check("R8 image frozen", {56'h0, b}, 64'h01);
        take_snap();
        rd(4'd0, b);
        check("R8 image refreshed", {56'h0, b}, 64'h02);

        // R11: sticky flag, ignored set-write, clearing write
        @(negedge clk);
        osc_stop = 1'b1;
        @(negedge clk);
        osc_stop = 1'b0;
        repeat (3) @(negedge clk);
        take_snap();
        rd(4'd8, b);
        check("R11 flag set and held", {56'h0, b}, 64'h80);
        wr(4'd8, 8'hFF);
        take_snap();
        rd(4'd8, b);
        check("R11 write of one ignored", {56'h0, b}, 64'h80);
        wr(4'd8, 8'h00);
        take_snap();
        rd(4'd8, b);
        check("R11 cleared by write", {56'h0, b}, 64'h00);

        finish_run();
    end

endmodule